// File: doc/BRIEF.md
# Multi-Line Receive Silo With Alarm

This block collects received characters from up to sixteen serial lines into one shared first-in first-out store. Each line presents a one-cycle strobe with an 8-bit character and two error flags. The block holds the character in a per-line slot, lets a fixed-priority arbiter pick one slot per cycle, and stores the character together with its line number and its error flags. A stored entry also records whether characters were lost before it. The host empties the store through a single 16-bit receive register. Each read of that register returns the oldest entry and removes it. Bit 15 is set while an entry is present, so the host can keep reading until the value turns non-negative.

A second register holds an alarm level and a receive-interrupt enable. With an alarm level of zero, the interrupt request is raised as soon as one character waits. With a nonzero level, the request is held back until that many characters have gathered. This lets a busy host service many characters per interrupt.

Top module: `rx_silo_mux`

## Requirements
- R1: With `reg_sel`=0, `reg_rdata` shows the oldest entry as {bit15=1, bit14 overrun, bit13 framing error, bit12 parity error, bits11:8 line, bits7:0 data}. A read strobe removes that entry. When the store is empty, the register reads 16'h0000 and a read changes nothing.
- R2: Bits 11:8 of an entry hold the index of the line whose strobe delivered the character.
- R3: Bit 12 copies the line's parity-error input and bit 13 copies its framing-error input, both sampled with the strobe.
- R4: Entries are read in the order they were stored, and up to 64 entries are held.
- R5: A character that reaches the store while 64 entries are held is discarded. Bit 14 is then set on the next entry that is stored, and only on that entry.
- R6: When several lines hold characters at once, one is stored per cycle, lowest line index first. The others keep waiting, and none is lost.
- R7: If a line strobes again while its earlier character is still waiting and is not stored on that edge, the new character replaces the old one and carries bit 14.
- R8: With `reg_sel`=1, a write sets the alarm level from bits 6:0 and the interrupt enable from bit 8. A read returns the same layout with all other bits 0. Both fields reset to 0.
- R9: `irq` is 1 only when the enable is 1. With alarm level 0, `irq` follows whether the store holds at least one entry.
- R10: With a nonzero alarm level L and the enable set, `irq` is 1 exactly while the fill is at least L.
- R11: Take a character strobed at a clock edge on a line with no competing waiting characters. It becomes readable after the following edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ln_valid | input | NUM_LINES | Per-line character strobe |
| ln_data | input | 8*NUM_LINES | Per-line character, line i at bits 8i+7:8i |
| ln_perr | input | NUM_LINES | Per-line parity error flag |
| ln_ferr | input | NUM_LINES | Per-line framing error (break) flag |
| reg_sel | input | 1 | Register select: 0 receive register, 1 control register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when reg_sel=0) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq | output | 1 | Receive interrupt request |

## Verification
Several properties are checked on every cycle. The fill never goes past the depth, and it moves by at most one entry upward per cycle. A discard while full leaves the fill unchanged and arms the overrun mark. The arbiter grants at most one line, and never a line above a waiting lower one. A read of an empty store does nothing, and the request never rises while the enable is clear. Other behaviour shows only through the bench's scenarios against its queue model: field packing, ordering across simultaneous lines, replacement of a waiting character, the single overrun-marked entry after a discard, and the alarm thresholds.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   localparam int RXS_DATA_W  = 8;
   localparam int RXS_LINE_W  = 4;
   localparam int RXS_ALARM_W = 7;

   // Stored entry, MSB first: overrun, framing, parity, line, data (bits 14:0)
   typedef struct packed {
      logic                  ovr;
      logic                  ferr;
      logic                  perr;
      logic [RXS_LINE_W-1:0] line;
      logic [RXS_DATA_W-1:0] data;
   } rxs_entry_t;

   localparam int RXS_ENTRY_W = $bits(rxs_entry_t);
endpackage

// File: rtl/rxs_capture.sv
module rxs_capture
   import rxs_pkg::*;
#(
   parameter int NUM_LINES = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_LINES-1:0]             ln_valid,
   input  logic [NUM_LINES*RXS_DATA_W-1:0]  ln_data,
   input  logic [NUM_LINES-1:0]             ln_perr,
   input  logic [NUM_LINES-1:0]             ln_ferr,
   input  logic [NUM_LINES-1:0]             grant,
   output logic [NUM_LINES-1:0]             pend,
   output rxs_entry_t [NUM_LINES-1:0]       held
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_slot
      logic       slot_full_q;
      rxs_entry_t slot_q;
      logic       still_waiting;

      // A held character that is not taken on this edge is being displaced
      assign still_waiting = slot_full_q & ~grant[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_full_q <= 1'b0;
            slot_q      <= '0;
         end else begin
            slot_full_q <= still_waiting | ln_valid[i];
            if (ln_valid[i]) begin
               slot_q.data <= ln_data[i*RXS_DATA_W +: RXS_DATA_W];
               slot_q.perr <= ln_perr[i];
               slot_q.ferr <= ln_ferr[i];
               slot_q.line <= RXS_LINE_W'(i);
               slot_q.ovr  <= still_waiting;
            end
         end
      end

      assign pend[i] = slot_full_q;
      assign held[i] = slot_q;
   end
endmodule

// File: rtl/rxs_arbiter.sv
module rxs_arbiter #(
   parameter int N         = 16,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   if (LOW_FIRST) begin : g_low_first
      // isolate the least significant set request
      assign grant = req & (~req + N'(1));
   end else begin : g_high_first
      always_comb begin
         grant = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i]) grant = N'(1) << i;
         end
      end
   end
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 15,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] din,
   input  logic             rd_en,
   output logic [WIDTH-1:0] dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] count_q;
   logic             wr_ok, rd_ok;

   assign full  = (count_q == CNT_W'(DEPTH));
   assign empty = (count_q == '0);
   assign wr_ok = wr_en & ~full;
   assign rd_ok = rd_en & ~empty;

   always_ff @(posedge clk) begin
      if (wr_ok) mem_q[wr_ptr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (wr_ok) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
         if (rd_ok) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
         count_q <= count_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
      end
   end

   assign dout  = mem_q[rd_ptr_q];
   assign count = count_q;
endmodule

// File: rtl/rxs_alarm.sv
module rxs_alarm #(
   parameter int CNT_W   = 7,
   parameter int ALARM_W = 7,
   localparam int CMP_W  = (CNT_W > ALARM_W) ? CNT_W : ALARM_W
) (
   input  logic [CNT_W-1:0]   count,
   input  logic               empty,
   input  logic [ALARM_W-1:0] alarm,
   input  logic               rie,
   output logic               flag,
   output logic               irq
);
   always_comb begin
      if (alarm == '0) flag = ~empty;
      else             flag = (CMP_W'(count) >= CMP_W'(alarm));
   end

   assign irq = flag & rie;
endmodule

// File: rtl/rx_silo_mux.sv
module rx_silo_mux
   import rxs_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int DEPTH     = 64,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_LINES-1:0]            ln_valid,
   input  logic [NUM_LINES*RXS_DATA_W-1:0] ln_data,
   input  logic [NUM_LINES-1:0]            ln_perr,
   input  logic [NUM_LINES-1:0]            ln_ferr,
   input  logic                            reg_sel,
   input  logic                            reg_wr,
   input  logic                            reg_rd,
   input  logic [15:0]                     reg_wdata,
   output logic [15:0]                     reg_rdata,
   output logic                            irq
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (NUM_LINES < 1 || NUM_LINES > (1 << RXS_LINE_W)) begin : g_bad_lines
      $error("rx_silo_mux: NUM_LINES must lie in 1..16");
   end
   if (DEPTH < 2 || DEPTH >= (1 << RXS_ALARM_W) || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rx_silo_mux: DEPTH must be a power of two below 128");
   end

   logic [NUM_LINES-1:0]       pend, grant;
   rxs_entry_t [NUM_LINES-1:0] held;
   logic [RXS_ENTRY_W-1:0]     sel_vec;
   rxs_entry_t                 push_ent;
   logic [RXS_ENTRY_W-1:0]     fifo_dout;
   logic [CNT_W-1:0]           count;
   logic                       full, empty;
   logic                       push_req, push_ok, pop;
   logic                       drop_q;
   logic [RXS_ALARM_W-1:0]     alarm_q;
   logic                       rie_q;
   logic                       rx_flag;

   rxs_capture #(.NUM_LINES(NUM_LINES)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .ln_valid(ln_valid),
      .ln_data (ln_data),
      .ln_perr (ln_perr),
      .ln_ferr (ln_ferr),
      .grant   (grant),
      .pend    (pend),
      .held    (held)
   );

   rxs_arbiter #(.N(NUM_LINES), .LOW_FIRST(LOW_FIRST)) u_arb (
      .req  (pend),
      .grant(grant)
   );

   // one-hot select of the granted slot
   always_comb begin
      sel_vec = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (grant[i]) sel_vec = sel_vec | held[i];
      end
   end

   assign push_req = |grant;
   assign push_ok  = push_req & ~full;
   assign pop      = reg_rd & ~reg_sel & ~empty;

   always_comb begin
      push_ent     = rxs_entry_t'(sel_vec);
      push_ent.ovr = push_ent.ovr | drop_q;
   end

   // remembers a discarded character until the next stored entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 drop_q <= 1'b0;
      else if (push_req && full)  drop_q <= 1'b1;
      else if (push_ok)           drop_q <= 1'b0;
   end

   rxs_fifo #(.DEPTH(DEPTH), .WIDTH(RXS_ENTRY_W)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(push_ok),
      .din  (push_ent),
      .rd_en(pop),
      .dout (fifo_dout),
      .count(count),
      .full (full),
      .empty(empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q <= '0;
         rie_q   <= 1'b0;
      end else if (reg_wr && reg_sel) begin
         alarm_q <= reg_wdata[RXS_ALARM_W-1:0];
         rie_q   <= reg_wdata[8];
      end
   end

   rxs_alarm #(.CNT_W(CNT_W), .ALARM_W(RXS_ALARM_W)) u_alarm (
      .count(count),
      .empty(empty),
      .alarm(alarm_q),
      .rie  (rie_q),
      .flag (rx_flag),
      .irq  (irq)
   );

   always_comb begin
      if (reg_sel)    reg_rdata = {7'd0, rie_q, 1'b0, alarm_q};
      else if (empty) reg_rdata = 16'h0000;
      else            reg_rdata = {1'b1, fifo_dout};
   end
endmodule

// File: rtl/rx_silo_mux_chk.sv
module rx_silo_mux_chk #(
   parameter int NUM_LINES = 16,
   parameter int DEPTH     = 64,
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_rd,
   input logic                 reg_sel,
   input logic                 irq,
   input logic                 rie_q,
   input logic                 drop_q,
   input logic [NUM_LINES-1:0] pend,
   input logic [NUM_LINES-1:0] grant,
   input logic [CNT_W-1:0]     count,
   input logic                 full,
   input logic                 empty
);
   a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   a_r4_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
      (count > $past(count)) |-> (count == $past(count) + 1'b1));

   a_r5_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (full && (|grant) && !(reg_rd && !reg_sel)) |=> (count == $past(count)));

   a_r5_mark_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (full && (|grant)) |=> drop_q);

   a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> ((pend & (grant - 1'b1)) == '0));

   a_r6_waiting_served: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |-> (grant != '0));

   a_r1_empty_read_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_sel && empty && grant == '0) |=> empty);

   a_r9_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> rie_q);
endmodule

bind rx_silo_mux rx_silo_mux_chk #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .reg_rd (reg_rd),
   .reg_sel(reg_sel),
   .irq    (irq),
   .rie_q  (rie_q),
   .drop_q (drop_q),
   .pend   (pend),
   .grant  (grant),
   .count  (count),
   .full   (full),
   .empty  (empty)
);

// File: tb/rx_silo_mux_test.sv
module rx_silo_mux_test;
   localparam int NL    = 16;
   localparam int DEPTH = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NL-1:0]   ln_valid = '0;
   logic [NL*8-1:0] ln_data = '0;
   logic [NL-1:0]   ln_perr = '0;
   logic [NL-1:0]   ln_ferr = '0;
   logic            reg_sel = 1'b0;
   logic            reg_wr = 1'b0;
   logic            reg_rd = 1'b0;
   logic [15:0]     reg_wdata = '0;
   logic [15:0]     reg_rdata;
   logic            irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   rx_silo_mux #(.NUM_LINES(NL), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .ln_valid(ln_valid), .ln_data(ln_data),
      .ln_perr(ln_perr), .ln_ferr(ln_ferr), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   always #10 clk = ~clk;

   // ---------------- behavioural reference model ----------------
   logic [14:0] m_q [$];
   bit          m_pend [NL];
   logic [14:0] m_hold [NL];
   bit          m_drop;
   logic [6:0]  m_alarm;
   bit          m_rie;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         for (int i = 0; i < NL; i++) begin m_pend[i] = 0; m_hold[i] = '0; end
         m_drop = 0; m_alarm = '0; m_rie = 0;
      end else begin
         int g;
         int sz;
         logic [14:0] e;
         g  = -1;
         sz = m_q.size();
         for (int i = 0; i < NL; i++) if (m_pend[i] && g < 0) g = i;
         if (reg_wr && reg_sel) begin m_alarm = reg_wdata[6:0]; m_rie = reg_wdata[8]; end
         if (reg_rd && !reg_sel && sz > 0) void'(m_q.pop_front());
         if (g >= 0) begin
            if (sz < DEPTH) begin
               e = m_hold[g];
               if (m_drop) e[14] = 1'b1;
               m_q.push_back(e);
               m_drop = 0;
            end else m_drop = 1;
         end
         for (int i = 0; i < NL; i++) begin
            bit lose;
            lose = m_pend[i] && (i != g);
            if (ln_valid[i]) begin
               m_hold[i] = {lose, ln_ferr[i], ln_perr[i], 4'(i), ln_data[i*8 +: 8]};
               m_pend[i] = 1;
            end else if (i == g) m_pend[i] = 0;
         end
      end
   end

   function automatic logic [15:0] exp_rdata();
      if (reg_sel) return {7'd0, m_rie, 1'b0, m_alarm};
      if (m_q.size() == 0) return 16'h0000;
      return {1'b1, m_q[0]};
   endfunction

   function automatic logic exp_irq();
      if (!m_rie) return 1'b0;
      if (m_alarm == 0) return m_q.size() != 0;
      return m_q.size() >= int'(m_alarm);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock, then compare outputs with the model away from the edge
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      #1;
      chk("R1/R9 per-cycle rdata", 32'(reg_rdata), 32'(exp_rdata()));
      chk("R9/R10 per-cycle irq", 32'(irq), 32'(exp_irq()));
   endtask

   task automatic strobe(input logic [NL-1:0] mask, input logic [7:0] base,
                         input logic pe, input logic fe);
      ln_valid = mask;
      for (int i = 0; i < NL; i++) ln_data[i*8 +: 8] = base + 8'(i);
      ln_perr = pe ? mask : '0;
      ln_ferr = fe ? mask : '0;
      cyc();
      ln_valid = '0; ln_perr = '0; ln_ferr = '0;
   endtask

   task automatic rd_rx(output logic [15:0] v);
      reg_sel = 1'b0; reg_rd = 1'b1;
      #1 v = reg_rdata;
      cyc();
      reg_rd = 1'b0;
   endtask

   task automatic wr_ctl(input logic [6:0] lvl, input logic en);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = {7'd0, en, 1'b0, lvl};
      cyc();
      reg_wr = 1'b0; reg_sel = 1'b0;
   endtask

   task automatic rd_ctl(output logic [15:0] v);
      reg_sel = 1'b1;
      #1 v = reg_rdata;
      reg_sel = 1'b0;
   endtask

   initial begin : watchdog
      while (cycles < 100000) begin @(posedge clk); cycles++; end
      errors++;
      $display("FAIL R4 watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 reset rdata", 32'(reg_rdata), 32'h0);
      chk("R9 reset irq", 32'(irq), 32'h0);
      rd_ctl(v);
      chk("R8 reset control", 32'(v), 32'h0);

      // R11 / R1 / R2 / R3: single character with parity error on line 5
      ln_data[5*8 +: 8] = 8'hA5; ln_valid[5] = 1'b1; ln_perr[5] = 1'b1;
      cyc();
      ln_valid = '0; ln_perr = '0;
      chk("R11 not yet readable", 32'(reg_rdata[15]), 32'h0);
      cyc();
      chk("R11 readable next edge", 32'(reg_rdata[15]), 32'h1);
      rd_rx(v);
      chk("R1/R2/R3 parity entry", 32'(v), 32'h95A5);
      // framing error on line 10
      ln_data[10*8 +: 8] = 8'h3C; ln_valid[10] = 1'b1; ln_ferr[10] = 1'b1;
      cyc();
      ln_valid = '0; ln_ferr = '0;
      cyc();
      rd_rx(v);
      chk("R2/R3 framing entry", 32'(v), 32'hAA3C);
      // empty read
      rd_rx(v);
      chk("R1 empty read value", 32'(v), 32'h0);
      chk("R1 empty read no effect", 32'(reg_rdata), 32'h0);

      // R6: three lines in one cycle
      strobe(16'h008A, 8'h10, 1'b0, 1'b0);
      repeat (3) cyc();
      rd_rx(v); chk("R6 first lowest line", 32'(v), 32'h8111);
      rd_rx(v); chk("R6 second line", 32'(v), 32'h8313);
      rd_rx(v); chk("R6 third line", 32'(v), 32'h8717);

      // R7: line 2 strobes again while its character is still waiting
      strobe(16'h0005, 8'h20, 1'b0, 1'b0);
      ln_data[2*8 +: 8] = 8'h99; ln_valid[2] = 1'b1;
      cyc();
      ln_valid = '0;
      repeat (2) cyc();
      rd_rx(v); chk("R7 line 0 entry", 32'(v), 32'h8020);
      rd_rx(v); chk("R7 replaced entry with overrun", 32'(v), 32'hC299);
      rd_rx(v); chk("R7 old character gone", 32'(v), 32'h0);

      // R4 / R5: fill, overflow, overrun mark on next stored entry
      for (int k = 0; k < DEPTH; k++) begin
         ln_valid[1] = 1'b1; ln_data[1*8 +: 8] = 8'(k);
         cyc();
      end
      ln_data[1*8 +: 8] = 8'hEE;
      cyc();
      ln_valid = '0;
      repeat (2) cyc();
      rd_rx(v); chk("R4 oldest first after fill", 32'(v), 32'h8100);
      ln_data[1*8 +: 8] = 8'h77; ln_valid[1] = 1'b1;
      cyc();
      ln_valid = '0;
      cyc();
      for (int k = 1; k < DEPTH; k++) begin
         rd_rx(v); chk("R4 order during drain", 32'(v), 32'h8100 | 32'(k));
      end
      rd_rx(v); chk("R5 overrun on entry after discard", 32'(v), 32'hC177);
      rd_rx(v); chk("R5 discarded character absent", 32'(v), 32'h0);

      // R10: alarm level 16
      wr_ctl(7'd16, 1'b1);
      rd_ctl(v); chk("R8 control readback", 32'(v), 32'h0110);
      for (int k = 0; k < 15; k++) begin
         ln_valid[4] = 1'b1; ln_data[4*8 +: 8] = 8'(k);
         cyc();
      end
      ln_valid = '0;
      repeat (2) cyc();
      chk("R10 below level", 32'(irq), 32'h0);
      strobe(16'h0010, 8'h50, 1'b0, 1'b0);
      cyc();
      chk("R10 at level", 32'(irq), 32'h1);
      rd_rx(v);
      chk("R10 dropped below level", 32'(irq), 32'h0);
      for (int k = 0; k < 15; k++) rd_rx(v);

      // R9: per-character interrupt, then disabled
      wr_ctl(7'd0, 1'b1);
      strobe(16'h0100, 8'h00, 1'b0, 1'b0);
      cyc();
      chk("R9 per-character raise", 32'(irq), 32'h1);
      rd_rx(v);
      chk("R9 clears when empty", 32'(irq), 32'h0);
      wr_ctl(7'd0, 1'b0);
      strobe(16'h0100, 8'h00, 1'b0, 1'b0);
      cyc();
      chk("R9 disabled no irq", 32'(irq), 32'h0);
      rd_rx(v);
      wr_ctl(7'd5, 1'b1);
      rd_ctl(v); chk("R8 second readback", 32'(v), 32'h0105);
      cyc();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule